// File: doc/BRIEF.md
# Event Counter with Overflow Freeze

This block is one channel of a performance monitor. A 48-bit counter adds one for each clock cycle in which the chosen single-bit event input is high. Software picks the event by writing a select code. It can preload the counter and can enable an interrupt on overflow, all through a small register port. Register reads are combinational, so the counter can be sampled at any moment without disturbing collection.

To stop counting after exactly N events, software preloads 2^48 - N and enables the overflow interrupt. The carry out of the top bit wraps the counter to zero, sets a sticky overflow flag and sends a one-cycle interrupt request to a central freeze controller. After a fixed delay, that controller drops the global counting enable. Events that arrive during the delay are still counted after the wrap, so software can account for the skew between the overflow and the freeze.

Top module: `epmon_top`

## Requirements
- R1: After reset the counter, the control register (address 1), the overflow flag and the global enable all read 0, and the interrupt request is low.
- R2: While the global enable is 1, the counter (address 0) adds exactly 1 at each clock edge where the event chosen by the select code is high. The select code is control bits [8:0]. The codes map to event inputs 0..10 in this order: 0x000, 0x001, 0x002, 0x003, 0x004, 0x050, 0x051, 0x0F8, 0x0F9, 0x1DF, 0x1E4. Events that are not selected have no effect.
- R3: A select code that is not in the R2 list selects no event, and the counter holds its value.
- R4: An increment from all ones carries out of bit 47. The counter becomes 0 and the overflow flag (status bit 0, address 2) sets. A preload of 2^48 - N therefore overflows on the Nth event.
- R5: When control bit 9 (interrupt enable) is 1, each overflow drives the interrupt request high for exactly one cycle, starting in the cycle after the wrap. When bit 9 is 0, an overflow does not raise the request.
- R6: The global enable (status bit 1) clears FREEZE_DELAY clock edges after the edge that samples the interrupt request. Until then the counter keeps counting past zero. With the event held high, the frozen value is FREEZE_DELAY + 1.
- R7: A software write to the counter in the same cycle as an increment loads exactly the written value.
- R8: Reading the counter while counting is active does not stop or disturb the counting.
- R9: The overflow flag stays set until software writes 1 to status bit 0. Writing 0 there leaves it set. Status bit 1 is written directly as the global enable.
- R10: While the global enable is 0, the counter holds its value whatever the event inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| events | input | NUM_EVT | Single-bit event sources |
| regAddr | input | 2 | Register address: 0 counter, 1 control, 2 status |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | CNT_W | Register write data |
| regRdData | output | CNT_W | Combinational register read data |
| pmiReq | output | 1 | Overflow interrupt request pulse |
| globalEn | output | 1 | Global counting enable |

## Verification
The hardest case to reach is the window between the wrap and the freeze. A natural overflow would need 2^48 events. The bench instead preloads the counter a few counts below the wrap, holds the selected event high and enables the interrupt. It then checks three things: the number of edges between the request and the drop of the global enable, that the counter froze at FREEZE_DELAY + 1, and that it stays there. Write-over-increment priority is tested by writing while the event is held high and reading the counter in the cycle right after the write.

// File: rtl/epmon_pkg.sv
package epmon_pkg;

  localparam int CNT_W_DEF  = 48;
  localparam int CODE_W     = 9;
  localparam int NUM_EVT    = 11;
  localparam int ADDR_W     = 2;

  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic cntWr;
    logic cntInc;
  } dpStrobe_t;

  // select code carried by each event input position
  function automatic logic [CODE_W-1:0] evtCode(input int idx);
    case (idx)
      0:       evtCode = 9'h000;
      1:       evtCode = 9'h001;
      2:       evtCode = 9'h002;
      3:       evtCode = 9'h003;
      4:       evtCode = 9'h004;
      5:       evtCode = 9'h050;
      6:       evtCode = 9'h051;
      7:       evtCode = 9'h0F8;
      8:       evtCode = 9'h0F9;
      9:       evtCode = 9'h1DF;
      10:      evtCode = 9'h1E4;
      default: evtCode = 9'h1FF;
    endcase
  endfunction

endpackage

// File: rtl/epmon_datapath.sv
module epmon_datapath
  import epmon_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic             carry
);

  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W:0]   incSum;

  assign incSum = {1'b0, cntQ} + ONE;
  // a write in the same cycle suppresses the increment and its carry
  assign carry  = strobe.cntInc & ~strobe.cntWr & incSum[CNT_W];
  assign cnt    = cntQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (strobe.cntWr) begin
      cntQ <= wrData;
    end else if (strobe.cntInc) begin
      cntQ <= incSum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/epmon_ctrl.sv
module epmon_ctrl
  import epmon_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0] events,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CODE_W:0]   cfgWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              carry,
  input  logic              globalEn,
  output dpStrobe_t         strobe,
  output logic              pmiReq,
  output logic              ovfSticky,
  output logic              swEnWr,
  output logic              swEnVal
);

  logic [CODE_W-1:0]  selCodeQ;
  logic               intEnQ;
  logic               ovfQ;
  logic               pmiQ;
  logic [NUM_EVT-1:0] hit;
  logic               evtActive;
  logic               ctrlWr;
  logic               statWr;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign statWr = regWrEn && (regAddr == ADDR_STAT);

  // event selection: one comparator per input
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_sel
    assign hit[i] = (selCodeQ == evtCode(i)) & events[i];
  end
  assign evtActive = |hit;

  always_comb begin
    strobe        = '0;
    strobe.cntWr  = regWrEn && (regAddr == ADDR_CNT);
    strobe.cntInc = globalEn & evtActive;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selCodeQ <= '0;
      intEnQ   <= 1'b0;
    end else if (ctrlWr) begin
      selCodeQ <= cfgWrData[CODE_W-1:0];
      intEnQ   <= cfgWrData[CODE_W];
    end
  end

  // sticky overflow: a new overflow wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovfQ <= 1'b0;
      pmiQ <= 1'b0;
    end else begin
      ovfQ <= carry | (ovfQ & ~(statWr & cfgWrData[0]));
      pmiQ <= carry & intEnQ;
    end
  end

  assign pmiReq    = pmiQ;
  assign ovfSticky = ovfQ;
  assign swEnWr    = statWr;
  assign swEnVal   = cfgWrData[1];

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CNT:  regRdData = cnt;
      ADDR_CTRL: begin
        regRdData[CODE_W-1:0] = selCodeQ;
        regRdData[CODE_W]     = intEnQ;
      end
      ADDR_STAT: begin
        regRdData[0] = ovfQ;
        regRdData[1] = globalEn;
      end
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/epmon_freeze.sv
module epmon_freeze #(
  parameter int FREEZE_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pmiReq,
  input  logic swEnWr,
  input  logic swEnVal,
  output logic globalEn
);

  localparam int DLY_W = $clog2(FREEZE_DELAY + 1);

  logic             enQ;
  logic             pendQ;
  logic [DLY_W-1:0] dlyQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enQ   <= 1'b0;
      pendQ <= 1'b0;
      dlyQ  <= '0;
    end else if (swEnWr) begin
      enQ   <= swEnVal;
      pendQ <= 1'b0;
    end else if (pmiReq) begin
      pendQ <= 1'b1;
      dlyQ  <= DLY_W'(FREEZE_DELAY - 1);
    end else if (pendQ) begin
      if (dlyQ == '0) begin
        enQ   <= 1'b0;
        pendQ <= 1'b0;
      end else begin
        dlyQ <= dlyQ - 1'b1;
      end
    end
  end

  assign globalEn = enQ;

endmodule

// File: rtl/epmon_top.sv
module epmon_top
  import epmon_pkg::*;
#(
  parameter int CNT_W        = CNT_W_DEF,
  parameter int FREEZE_DELAY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] events,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [CNT_W-1:0]   regWrData,
  output logic [CNT_W-1:0]   regRdData,
  output logic               pmiReq,
  output logic               globalEn
);

  dpStrobe_t        dpStrobe;
  logic [CNT_W-1:0] cntQ;
  logic             carry;
  logic             ovfSticky;
  logic             swEnWr;
  logic             swEnVal;

  epmon_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .events    (events),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .cfgWrData (regWrData[CODE_W:0]),
    .regRdData (regRdData),
    .cnt       (cntQ),
    .carry     (carry),
    .globalEn  (globalEn),
    .strobe    (dpStrobe),
    .pmiReq    (pmiReq),
    .ovfSticky (ovfSticky),
    .swEnWr    (swEnWr),
    .swEnVal   (swEnVal)
  );

  epmon_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (dpStrobe),
    .wrData (regWrData),
    .cnt    (cntQ),
    .carry  (carry)
  );

  epmon_freeze #(.FREEZE_DELAY(FREEZE_DELAY)) u_frz (
    .clk      (clk),
    .rst_n    (rst_n),
    .pmiReq   (pmiReq),
    .swEnWr   (swEnWr),
    .swEnVal  (swEnVal),
    .globalEn (globalEn)
  );

endmodule

// File: rtl/epmon_checker.sv
module epmon_checker #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cntQ,
  input logic             cntWr,
  input logic [CNT_W-1:0] wrData,
  input logic             carry,
  input logic             ovfSticky,
  input logic             pmiReq,
  input logic             globalEn
);

  assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cntWr |=> (cntQ == $past(cntQ) || cntQ == $past(cntQ) + 1'b1));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cntWr |=> cntQ == $past(wrData));

  assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (ovfSticky && cntQ == '0));

  assert_pmi_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pmiReq |=> !pmiReq);

  assert_pmi_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pmiReq |-> ovfSticky);

  assert_frozen_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!globalEn && !cntWr) |=> $stable(cntQ));

endmodule

bind epmon_top epmon_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cntQ      (cntQ),
  .cntWr     (dpStrobe.cntWr),
  .wrData    (regWrData),
  .carry     (carry),
  .ovfSticky (ovfSticky),
  .pmiReq    (pmiReq),
  .globalEn  (globalEn)
);

// File: tb/epmon_top_bench.sv
module epmon_top_bench;

  localparam int W  = 48;
  localparam int NE = 11;
  localparam int D  = 4;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] events = '0;
  logic [1:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [W-1:0]  regWrData = '0;
  logic [W-1:0]  regRdData;
  logic          pmiReq;
  logic          globalEn;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int pmiCount = 0;
  int pmiCycle = 0;
  int fallCycle = 0;
  logic prevEn = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  epmon_top #(.CNT_W(W), .FREEZE_DELAY(D)) u_epmon_top (
    .clk(clk), .rst_n(rst_n), .events(events), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .pmiReq(pmiReq), .globalEn(globalEn)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pmiReq) begin
      pmiCount <= pmiCount + 1;
      pmiCycle <= cyc;
    end
    if (prevEn && !globalEn) fallCycle <= cyc;
    prevEn <= globalEn;
  end

  function automatic logic [8:0] codeOf(input int i);
    logic [8:0] t [NE];
    t = '{9'h000, 9'h001, 9'h002, 9'h003, 9'h004, 9'h050, 9'h051,
          9'h0F8, 9'h0F9, 9'h1DF, 9'h1E4};
    return t[i];
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [W-1:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    regRead(2'd0, v); check(v == '0, "R1 counter", v, '0);
    regRead(2'd1, v); check(v == '0, "R1 control", v, '0);
    regRead(2'd2, v); check(v == '0, "R1 status", v, '0);
    check(pmiReq == 1'b0, "R1 pmiReq", W'(pmiReq), '0);
  endtask

  task automatic t_codes;
    logic [W-1:0] v;
    regWrite(2'd2, W'(2));
    for (int i = 0; i < NE; i++) begin
      regWrite(2'd1, W'(codeOf(i)));
      regWrite(2'd0, '0);
      events = ~(NE'(1) << i);
      repeat (3) @(negedge clk);
      events = NE'(1) << i;
      repeat (5) @(negedge clk);
      events = '0;
      @(negedge clk);
      regRead(2'd0, v);
      check(v == W'(5), $sformatf("R2 code %0h", codeOf(i)), v, W'(5));
    end
  endtask

  task automatic t_unknown;
    logic [W-1:0] v;
    regWrite(2'd0, W'(77));
    regWrite(2'd1, W'(9'h123));
    events = '1;
    repeat (10) @(negedge clk);
    regRead(2'd0, v); check(v == W'(77), "R3 code 0x123", v, W'(77));
    regWrite(2'd1, W'(9'h005));
    repeat (10) @(negedge clk);
    regRead(2'd0, v); check(v == W'(77), "R3 code 0x005", v, W'(77));
    events = '0;
  endtask

  task automatic t_priority_read;
    logic [W-1:0] v;
    logic [W-1:0] prev;
    regWrite(2'd1, W'(9'h000));
    events = NE'(1);
    regWrite(2'd0, W'(48'h1234));
    regRead(2'd0, v);
    check(v == W'(48'h1234), "R7 write wins", v, W'(48'h1234));
    prev = v;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      regRead(2'd0, v);
      check(v == prev + 1'b1, "R8 read while counting", v, prev + 1'b1);
      prev = v;
    end
    events = '0;
  endtask

  task automatic t_ovf_noint;
    logic [W-1:0] v;
    int p0;
    p0 = pmiCount;
    regWrite(2'd1, W'(9'h000));
    regWrite(2'd0, TOP - W'(2));
    events = NE'(1);
    repeat (3) @(negedge clk);
    events = '0;
    regRead(2'd0, v); check(v == '0, "R4 wrap to zero", v, '0);
    regRead(2'd2, v); check(v == W'(3), "R4 flag set, enable kept", v, W'(3));
    @(negedge clk);
    check(pmiCount == p0, "R5 no request when disabled", W'(pmiCount), W'(p0));
    events = NE'(1);
    repeat (2) @(negedge clk);
    events = '0;
    regRead(2'd0, v); check(v == W'(2), "R4 counts after wrap", v, W'(2));
  endtask

  task automatic t_w1c;
    logic [W-1:0] v;
    regWrite(2'd2, W'(2));
    regRead(2'd2, v); check(v[0] == 1'b1, "R9 write 0 keeps flag", v, W'(3));
    regWrite(2'd2, W'(3));
    regRead(2'd2, v); check(v == W'(2), "R9 write 1 clears flag", v, W'(2));
  endtask

  task automatic t_freeze;
    logic [W-1:0] v;
    int p0;
    p0 = pmiCount;
    regWrite(2'd1, W'(10'h200));
    events = NE'(1);
    regWrite(2'd0, TOP - W'(5));
    repeat (6 + D + 10) @(negedge clk);
    regRead(2'd0, v); check(v == W'(D + 1), "R6 frozen value", v, W'(D + 1));
    regRead(2'd2, v); check(v == W'(1), "R6 enable cleared", v, W'(1));
    check(pmiCount == p0 + 1, "R5 one request", W'(pmiCount), W'(p0 + 1));
    check(fallCycle - pmiCycle == D + 1, "R6 freeze delay",
          W'(fallCycle - pmiCycle), W'(D + 1));
    repeat (8) @(negedge clk);
    regRead(2'd0, v); check(v == W'(D + 1), "R10 held while disabled", v, W'(D + 1));
    events = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_codes;
    t_unknown;
    t_priority_read;
    t_ovf_noint;
    t_w1c;
    t_freeze;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule